// File: doc/BRIEF.md
# Time Stamp Input Switch Scheduler

This block holds the master time code for a group of receiver channels and changes each channel's input selection at scheduled moments. One of two reference clock inputs is chosen, its rising edges are synchronised into the system clock domain, and a programmable divider turns them into a slow tick (nominally every 10 µs). Each tick advances a free-running time stamp counter that wraps to zero after its all-ones value.

A host fills a schedule table through a simple write-only register port. Each entry names a target time, a channel and the input setting that channel should take. After every tick the table is walked one entry per system clock. Every pending entry whose target time equals the new time stamp is applied to its channel's select register and then retired. The current time stamp and all channel selects are presented as outputs for the receivers and for packet time stamping.

Top module: `switch_sched`

## Requirements
- R1: The time stamp output is 0 after reset, increases by exactly one on every tick, and wraps from all ones to zero.
- R2: A tick occurs on every R-th rising edge of the selected reference, where R is host address 0 bits [DIV_W-1:0]; R = 0 behaves as R = 1, and reset loads R = DIV_DEFAULT.
- R3: Host address 1 bit 0 selects the reference (0 = refClkA, 1 = refClkB); edges on the other reference have no effect on the time stamp.
- R4: Any write to host address 0 restarts the divider edge count at zero, so the next tick needs a full R edges.
- R5: A write to address 2 stages a target time (bits [TS_W-1:0]); a write to address 3 fills the entry whose index is at bit 0 upward, with channel at bit 8 upward, select value at bit 16 upward and valid at bit 31, using the staged time; writing valid = 0 withdraws a pending entry.
- R6: After each tick the entries are examined in ascending index order, one per clock, over NUM_ENTRIES clocks; each valid entry whose time equals the new time stamp loads its select value into its channel, the highest index winning when several hit one channel; the tick period must exceed NUM_ENTRIES clocks.
- R7: An applied entry is retired and is not applied again when the time stamp wraps back to its target time.
- R8: Channel c's select sits at chanSel bits [c*SEL_W +: SEL_W] and changes only through an applied entry, never through other host writes.
- R9: Synchronous active-high reset clears the time stamp, the divider count, every entry's valid flag and every channel select, restores R = DIV_DEFAULT and selects refClkA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| refClkA | input | 1 | Reference clock source 0, asynchronous |
| refClkB | input | 1 | Reference clock source 1, asynchronous |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 2 | Host register address |
| hostWrData | input | 32 | Host write data |
| timeStamp | output | TS_W | Current time stamp |
| chanSel | output | NUM_CHAN*SEL_W | Packed per-channel input selects |

## Verification
The bench builds the block with an 8-bit time stamp, an 8-entry table and a default ratio of 3, keeping 16 channels and 2-bit selects. The narrow counter brings a full wrap within a few thousand clocks, so the retirement of applied entries can be shown by passing their target time a second time. The short table keeps the scan well inside a tick made of two reference edges, which lets the bench run many ticks with a mix of random entries, source swaps and ratio changes.

// File: rtl/switch_sched_pkg.sv
package switch_sched_pkg;

  localparam int HOST_ADDR_W = 2;
  localparam int HOST_DATA_W = 32;

  localparam logic [HOST_ADDR_W-1:0] ADDR_DIV    = 2'd0;
  localparam logic [HOST_ADDR_W-1:0] ADDR_SRC    = 2'd1;
  localparam logic [HOST_ADDR_W-1:0] ADDR_TIME   = 2'd2;
  localparam logic [HOST_ADDR_W-1:0] ADDR_COMMIT = 2'd3;

  localparam int COMMIT_IDX_LSB   = 0;
  localparam int COMMIT_CHAN_LSB  = 8;
  localparam int COMMIT_SEL_LSB   = 16;
  localparam int COMMIT_VALID_BIT = 31;

  typedef struct packed {
    logic tsStep;
    logic scanOn;
  } schedStrobe_t;

endpackage

// File: rtl/switch_sched_edge.sv
module switch_sched_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic risePulse
);

  logic [SYNC_STAGES:0] shiftQ;

  always_ff @(posedge clk) begin
    if (rst) shiftQ <= '0;
    else     shiftQ <= {shiftQ[SYNC_STAGES-1:0], rawIn};
  end

  assign risePulse = shiftQ[SYNC_STAGES-1] & ~shiftQ[SYNC_STAGES];

endmodule

// File: rtl/switch_sched_ctrl.sv
module switch_sched_ctrl
  import switch_sched_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int NUM_ENTRIES = 32,
  parameter int IDX_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refClkA,
  input  logic             refClkB,
  input  logic             srcSel,
  input  logic [DIV_W-1:0] divRatio,
  input  logic             divLoad,
  output schedStrobe_t     strobe,
  output logic [IDX_W-1:0] scanIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic [1:0]       refRaw;
  logic [1:0]       refRise;
  logic             srcEdge;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] lastCnt;
  logic             tick;
  logic             scanActive;

  assign refRaw = {refClkB, refClkA};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_ref
      switch_sched_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
        .clk      (clk),
        .rst      (rst),
        .rawIn    (refRaw[g]),
        .risePulse(refRise[g])
      );
    end
  endgenerate

  assign srcEdge = refRise[srcSel];

  // ratio of zero is treated as one edge per tick
  assign lastCnt = (divRatio == '0) ? '0 : divRatio - 1'b1;
  assign tick    = srcEdge && (divCnt == lastCnt) && !divLoad;

  always_ff @(posedge clk) begin
    if (rst)          divCnt <= '0;
    else if (divLoad) divCnt <= '0;
    else if (srcEdge) divCnt <= tick ? '0 : divCnt + 1'b1;
  end

  // sequential table walk, one entry per clock after each tick
  always_ff @(posedge clk) begin
    if (rst) begin
      scanActive <= 1'b0;
      scanIdx    <= '0;
    end else if (tick) begin
      scanActive <= 1'b1;
      scanIdx    <= '0;
    end else if (scanActive) begin
      if (scanIdx == LAST_IDX) scanActive <= 1'b0;
      else                     scanIdx    <= scanIdx + 1'b1;
    end
  end

  assign strobe.tsStep = tick;
  assign strobe.scanOn = scanActive;

  // R2: divider count never passes the programmed ratio
  p_div_bound_r2: assert property (@(posedge clk) disable iff (rst)
    divCnt <= lastCnt);

  // R6: scan ends after the last entry unless a new tick restarts it
  p_scan_len_r6: assert property (@(posedge clk) disable iff (rst)
    scanActive && (scanIdx == LAST_IDX) && !tick |=> !scanActive);

  // R6: a tick never lands before the previous scan reached its last entry
  p_scan_fits_r6: assert property (@(posedge clk) disable iff (rst)
    tick |-> (!scanActive || scanIdx == LAST_IDX));

endmodule

// File: rtl/switch_sched_dp.sv
module switch_sched_dp
  import switch_sched_pkg::*;
#(
  parameter int TS_W        = 32,
  parameter int NUM_CHAN    = 16,
  parameter int SEL_W       = 2,
  parameter int NUM_ENTRIES = 32,
  parameter int DIV_W       = 16,
  parameter int DIV_DEFAULT = 1000,
  parameter int IDX_W       = 5,
  parameter int CHAN_W      = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      hostWrEn,
  input  logic [HOST_ADDR_W-1:0]    hostAddr,
  input  logic [HOST_DATA_W-1:0]    hostWrData,
  input  schedStrobe_t              strobe,
  input  logic [IDX_W-1:0]          scanIdx,
  output logic                      srcSel,
  output logic [DIV_W-1:0]          divRatio,
  output logic                      divLoad,
  output logic [TS_W-1:0]           timeStamp,
  output logic [NUM_CHAN*SEL_W-1:0] chanSel
);

  logic             wrSrc;
  logic             wrTime;
  logic             wrCommit;
  logic [IDX_W-1:0] cmtIdx;
  logic [CHAN_W-1:0] cmtChan;
  logic [SEL_W-1:0] cmtSel;
  logic             cmtValid;
  logic             cmtIdxOk;
  logic             unusedHostBits;

  logic [TS_W-1:0]   stagedTime;
  logic [TS_W-1:0]   tsQ;
  logic [NUM_ENTRIES-1:0] entValid;
  logic [TS_W-1:0]   entTime [NUM_ENTRIES];
  logic [CHAN_W-1:0] entChan [NUM_ENTRIES];
  logic [SEL_W-1:0]  entSel  [NUM_ENTRIES];
  logic [SEL_W-1:0]  selQ    [NUM_CHAN];

  logic              hit;
  logic [CHAN_W-1:0] hitChan;
  logic [SEL_W-1:0]  hitSel;

  // host register decode
  assign divLoad  = hostWrEn && (hostAddr == ADDR_DIV);
  assign wrSrc    = hostWrEn && (hostAddr == ADDR_SRC);
  assign wrTime   = hostWrEn && (hostAddr == ADDR_TIME);
  assign wrCommit = hostWrEn && (hostAddr == ADDR_COMMIT);

  assign cmtIdx   = hostWrData[COMMIT_IDX_LSB  +: IDX_W];
  assign cmtChan  = hostWrData[COMMIT_CHAN_LSB +: CHAN_W];
  assign cmtSel   = hostWrData[COMMIT_SEL_LSB  +: SEL_W];
  assign cmtValid = hostWrData[COMMIT_VALID_BIT];
  assign cmtIdxOk = (32'(cmtIdx) < NUM_ENTRIES);

  assign unusedHostBits = ^hostWrData;

  always_ff @(posedge clk) begin
    if (rst) begin
      divRatio <= DIV_W'(DIV_DEFAULT);
      srcSel   <= 1'b0;
    end else begin
      if (divLoad) divRatio <= hostWrData[DIV_W-1:0];
      if (wrSrc)   srcSel   <= hostWrData[0];
    end
  end

  always_ff @(posedge clk) begin
    if (wrTime) stagedTime <= hostWrData[TS_W-1:0];
  end

  // master time code
  always_ff @(posedge clk) begin
    if (rst)                tsQ <= '0;
    else if (strobe.tsStep) tsQ <= tsQ + 1'b1;
  end

  assign timeStamp = tsQ;

  // schedule table payload: written only by the host
  always_ff @(posedge clk) begin
    if (wrCommit && cmtIdxOk) begin
      entTime[cmtIdx] <= stagedTime;
      entChan[cmtIdx] <= cmtChan;
      entSel[cmtIdx]  <= cmtSel;
    end
  end

  // compare the entry under the scan pointer against the current time
  assign hit     = strobe.scanOn && entValid[scanIdx] && (entTime[scanIdx] == tsQ);
  assign hitChan = entChan[scanIdx];
  assign hitSel  = entSel[scanIdx];

  // valid flags: host commit takes priority over retirement on a collision
  always_ff @(posedge clk) begin
    if (rst) begin
      entValid <= '0;
    end else begin
      if (hit)                  entValid[scanIdx] <= 1'b0;
      if (wrCommit && cmtIdxOk) entValid[cmtIdx]  <= cmtValid;
    end
  end

  generate
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      always_ff @(posedge clk) begin
        if (rst)                                 selQ[c] <= '0;
        else if (hit && hitChan == CHAN_W'(c))   selQ[c] <= hitSel;
      end
      assign chanSel[c*SEL_W +: SEL_W] = selQ[c];
    end
  endgenerate

  // R1: time stamp moves only by a single step (wrap included)
  p_ts_step_r1: assert property (@(posedge clk) disable iff (rst)
    (tsQ != $past(tsQ)) |-> (tsQ == $past(tsQ) + 1'b1));

  // R8: selects change only while the table walk is running
  p_sel_scan_only_r8: assert property (@(posedge clk) disable iff (rst)
    (chanSel != $past(chanSel)) |-> $past(strobe.scanOn));

  // R7: an applied entry is retired unless the host rewrote it that cycle
  p_applied_retired_r7: assert property (@(posedge clk) disable iff (rst)
    hit && !(wrCommit && cmtIdx == scanIdx) |=> !entValid[$past(scanIdx)]);

endmodule

// File: rtl/switch_sched.sv
module switch_sched
  import switch_sched_pkg::*;
#(
  parameter int TS_W        = 32,
  parameter int NUM_CHAN    = 16,
  parameter int SEL_W       = 2,
  parameter int NUM_ENTRIES = 32,
  parameter int DIV_W       = 16,
  parameter int DIV_DEFAULT = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      refClkA,
  input  logic                      refClkB,
  input  logic                      hostWrEn,
  input  logic [HOST_ADDR_W-1:0]    hostAddr,
  input  logic [HOST_DATA_W-1:0]    hostWrData,
  output logic [TS_W-1:0]           timeStamp,
  output logic [NUM_CHAN*SEL_W-1:0] chanSel
);

  localparam int IDX_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int CHAN_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;

  schedStrobe_t     strobe;
  logic [IDX_W-1:0] scanIdx;
  logic             srcSel;
  logic [DIV_W-1:0] divRatio;
  logic             divLoad;

  switch_sched_ctrl #(
    .DIV_W      (DIV_W),
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W      (IDX_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .refClkA (refClkA),
    .refClkB (refClkB),
    .srcSel  (srcSel),
    .divRatio(divRatio),
    .divLoad (divLoad),
    .strobe  (strobe),
    .scanIdx (scanIdx)
  );

  switch_sched_dp #(
    .TS_W       (TS_W),
    .NUM_CHAN   (NUM_CHAN),
    .SEL_W      (SEL_W),
    .NUM_ENTRIES(NUM_ENTRIES),
    .DIV_W      (DIV_W),
    .DIV_DEFAULT(DIV_DEFAULT),
    .IDX_W      (IDX_W),
    .CHAN_W     (CHAN_W)
  ) i_dp (
    .clk       (clk),
    .rst       (rst),
    .hostWrEn  (hostWrEn),
    .hostAddr  (hostAddr),
    .hostWrData(hostWrData),
    .strobe    (strobe),
    .scanIdx   (scanIdx),
    .srcSel    (srcSel),
    .divRatio  (divRatio),
    .divLoad   (divLoad),
    .timeStamp (timeStamp),
    .chanSel   (chanSel)
  );

endmodule

// File: tb/test_switch_sched.sv
module test_switch_sched;

  localparam int CLK_PERIOD  = 10;
  localparam int TS_W        = 8;
  localparam int NUM_CHAN    = 16;
  localparam int SEL_W       = 2;
  localparam int NUM_ENTRIES = 8;
  localparam int DIV_W       = 8;
  localparam int DIV_DEFAULT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refClkA = 1'b0;
  logic refClkB = 1'b0;
  logic hostWrEn = 1'b0;
  logic [1:0]  hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic [TS_W-1:0] timeStamp;
  logic [NUM_CHAN*SEL_W-1:0] chanSel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model
  logic [TS_W-1:0]  mTs;
  int               mCnt;
  int               mDiv;
  int               mSrc;
  bit               mValid [NUM_ENTRIES];
  logic [TS_W-1:0]  mTime  [NUM_ENTRIES];
  int               mChan  [NUM_ENTRIES];
  logic [SEL_W-1:0] mSel   [NUM_ENTRIES];
  logic [SEL_W-1:0] mSelCh [NUM_CHAN];

  always #(CLK_PERIOD/2) clk = ~clk;

  switch_sched #(
    .TS_W(TS_W), .NUM_CHAN(NUM_CHAN), .SEL_W(SEL_W),
    .NUM_ENTRIES(NUM_ENTRIES), .DIV_W(DIV_W), .DIV_DEFAULT(DIV_DEFAULT)
  ) i_switch_sched (
    .clk(clk), .rst(rst), .refClkA(refClkA), .refClkB(refClkB),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .timeStamp(timeStamp), .chanSel(chanSel)
  );

  function automatic logic [NUM_CHAN*SEL_W-1:0] expSel();
    logic [NUM_CHAN*SEL_W-1:0] v = '0;
    for (int c = 0; c < NUM_CHAN; c++) v[c*SEL_W +: SEL_W] = mSelCh[c];
    return v;
  endfunction

  function automatic int effRatio();
    return (mDiv == 0) ? 1 : mDiv;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkTs(input string req);
    check(timeStamp === mTs, req, 64'(timeStamp), 64'(mTs));
  endtask

  task automatic checkSel(input string req);
    check(chanSel === expSel(), req, 64'(chanSel), 64'(expSel()));
  endtask

  task automatic modelReset();
    mTs = '0; mCnt = 0; mDiv = DIV_DEFAULT; mSrc = 0;
    for (int i = 0; i < NUM_ENTRIES; i++) mValid[i] = 1'b0;
    for (int c = 0; c < NUM_CHAN; c++) mSelCh[c] = '0;
  endtask

  task automatic modelEdge();
    mCnt++;
    if (mCnt >= effRatio()) begin
      mCnt = 0;
      mTs  = mTs + 1'b1;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (mValid[i] && mTime[i] == mTs) begin
          mSelCh[mChan[i]] = mSel[i];
          mValid[i] = 1'b0;
        end
      end
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    modelReset();
  endtask

  task automatic hostWrite(input logic [1:0] addr, input logic [31:0] data);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = addr; hostWrData = data;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic setRatio(input int r);
    hostWrite(2'd0, 32'(r));
    mDiv = r; mCnt = 0;
  endtask

  task automatic setSrc(input int s);
    hostWrite(2'd1, 32'(s));
    mSrc = s;
  endtask

  task automatic writeEntry(input int idx, input logic [TS_W-1:0] t, input int ch,
                            input logic [SEL_W-1:0] s, input bit v);
    logic [31:0] d = '0;
    hostWrite(2'd2, 32'(t));
    d[0 +: 8]  = 8'(idx);
    d[8 +: 8]  = 8'(ch);
    d[16 +: 8] = 8'(s);
    d[31]      = v;
    hostWrite(2'd3, d);
    mValid[idx] = v; mTime[idx] = t; mChan[idx] = ch; mSel[idx] = s;
  endtask

  task automatic pulses(input int src, input int n, input int lowLen);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (src == 0) refClkA = 1'b1; else refClkB = 1'b1;
      repeat (3) @(negedge clk);
      refClkA = 1'b0; refClkB = 1'b0;
      repeat (lowLen) @(negedge clk);
      if (src == mSrc) modelEdge();
    end
    repeat (NUM_ENTRIES + 8) @(negedge clk);
  endtask

  task automatic advanceTicks(input int k);
    int n = k * effRatio() - mCnt;
    if (n > 0) pulses(mSrc, n, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int t0;
    logic [TS_W-1:0] oldT;
    void'($urandom(32'h5eed_1234));
    modelReset();
    doReset();

    // R9 / R1: reset state
    @(negedge clk);
    checkTs("R1 reset time stamp");
    checkSel("R9 reset selects");

    // R2: default ratio of 3
    pulses(0, 7, 3);
    checkTs("R2 default ratio");

    // R3: other source ignored, then swap sources
    pulses(1, 5, 3);
    checkTs("R3 unselected B ignored");
    setSrc(1);
    pulses(1, 3, 3);
    checkTs("R3 source B counts");
    pulses(0, 4, 3);
    checkTs("R3 unselected A ignored");
    setSrc(0);

    // R4: rewriting the ratio restarts the count
    setRatio(3);
    pulses(0, 2, 3);
    setRatio(3);
    pulses(0, 2, 3);
    checkTs("R4 restart withholds tick");
    pulses(0, 1, 3);
    checkTs("R4 tick after full count");

    // R2: ratio zero acts as one
    setRatio(0);
    pulses(0, 3, 10);
    checkTs("R2 ratio zero");

    // R8: host writes other than entries leave selects alone
    setRatio(2);
    checkSel("R8 selects untouched by config writes");

    // R6: two hits on one channel, higher index wins
    writeEntry(5, mTs + 8'd2, 3, 2'd2, 1'b1);
    writeEntry(2, mTs + 8'd2, 3, 2'd1, 1'b1);
    writeEntry(6, mTs + 8'd1, 9, 2'd3, 1'b1);
    advanceTicks(1);
    checkSel("R6 single hit applied");
    advanceTicks(1);
    checkSel("R6 highest index wins");
    check(chanSel[3*SEL_W +: SEL_W] == 2'd2, "R6 channel 3 value",
          64'(chanSel[3*SEL_W +: SEL_W]), 64'd2);

    // R5: withdrawn entry is not applied
    writeEntry(1, mTs + 8'd1, 7, 2'd3, 1'b1);
    writeEntry(1, mTs + 8'd1, 7, 2'd3, 1'b0);
    advanceTicks(1);
    checkSel("R5 withdrawn entry");
    check(chanSel[7*SEL_W +: SEL_W] == 2'd0, "R5 channel 7 value",
          64'(chanSel[7*SEL_W +: SEL_W]), 64'd0);

    // R7 / R1: retirement across a wrap
    t0 = int'(mTs) + 2;
    writeEntry(0, 8'(t0), 0, 2'd1, 1'b1);
    writeEntry(4, 8'(t0 + 3), 0, 2'd2, 1'b1);
    advanceTicks(2);
    checkSel("R7 first entry applied");
    advanceTicks(3);
    checkSel("R7 second entry applied");
    advanceTicks((255 - int'(mTs)) % 256);
    check(timeStamp == 8'hFF, "R1 reaches all ones", 64'(timeStamp), 64'hFF);
    advanceTicks(1);
    check(timeStamp == 8'h00, "R1 wraps to zero", 64'(timeStamp), 64'h00);
    advanceTicks(t0 + 1);
    checkTs("R1 after wrap");
    check(chanSel[1:0] == 2'd2, "R7 no reapply after wrap", 64'(chanSel[1:0]), 64'd2);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int choice = int'($urandom_range(0, 9));
      if (choice == 0) setSrc(int'($urandom_range(0, 1)));
      if (choice == 1) setRatio(int'($urandom_range(2, 4)));
      if (choice >= 3) writeEntry(int'($urandom_range(0, NUM_ENTRIES - 1)),
                                  mTs + 8'($urandom_range(1, 6)),
                                  int'($urandom_range(0, NUM_CHAN - 1)),
                                  2'($urandom_range(0, 3)),
                                  ($urandom_range(0, 7) != 0));
      if ($urandom_range(0, 4) == 0) pulses(1 - mSrc, int'($urandom_range(1, 4)), 3);
      pulses(mSrc, int'($urandom_range(1, 10)), 3);
      checkTs("R2 random time stamp");
      checkSel("R6 random selects");
    end

    // R9: reset mid-run clears entries, restores default ratio and source A
    setSrc(1);
    setRatio(2);
    oldT = mTs + 8'd3;
    writeEntry(3, oldT, 12, 2'd3, 1'b1);
    doReset();
    @(negedge clk);
    checkTs("R9 time stamp cleared");
    checkSel("R9 selects cleared");
    pulses(1, 3, 3);
    checkTs("R9 source back to A");
    pulses(0, 3, 3);
    checkTs("R9 default ratio restored");
    advanceTicks((int'(oldT) - int'(mTs) + 256) % 256 + 1);
    checkSel("R9 entries cleared");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule